// File: doc/BRIEF.md
# Triggered Waveform Averager

This block averages repeated, trigger-framed waveforms sample by sample. Each shot is a burst of `WAVE_LEN` beats, one sample per beat for each of four pickup channels. The shot opens on a beat that has both valid and trigger set. For every sample position the block keeps a running sum across the shots of a round. A round holds 2^N shots, where N is a programmable exponent. Because the shot count is a power of two, the average is an arithmetic right shift of the sum by N.

A round may be published in one of two ways. In the first, only the finished average appears, once the last shot of the round has been added. In the second, the scaled partial sum appears after every shot. When a round completes, the block either starts the next round on the following trigger or holds its result until software restarts it. A shot counter reports progress through the round in both publish modes. A restart pulse, or any write of the exponent, throws away the sums and the counter. The accumulators sit in a memory per channel, one word per sample position. Each word is read, added to and written back through a one-stage pipeline.

Top module: `wfa_averager`

## Requirements
- R1: After reset, out_valid, shot_count and round_done are 0 and the exponent N is 1. With no exponent write, a round is therefore two shots.
- R2: A shot is the accepted beat with smp_valid=1 and smp_trig=1, followed by the next WAVE_LEN-1 beats with smp_valid=1. Beats with smp_valid=0 are skipped. A trigger that arrives inside a shot is taken as an ordinary sample.
- R3: For a published shot, out_btn[c] (c=0..3 for channels A..D) at beat position i equals the signed sum of that channel's sample i over the shots of the round so far, arithmetically shifted right by N and truncated to SAMPLE_W bits. The value appears with out_valid two clock cycles after the beat that carried the sample.
- R4: With N=0, every shot forms a complete round, and the shot's samples come out unchanged.
- R5: With cfg_show_all=0, only the last shot of a round is published. With cfg_show_all=1, every shot is published.
- R6: shot_count counts the shots of the current round completed so far, up to 2^N. It advances in both publish modes.
- R7: round_done rises when shot_count reaches 2^N. With cfg_hold_done=0, the next trigger starts a new round: sums start from zero, and round_done and shot_count return to 0 before that shot completes.
- R8: With cfg_hold_done=1 and round_done set, triggers are ignored: no output appears and shot_count stays where it is.
- R9: An avg_restart pulse or a cfg_shift_wr pulse clears shot_count and round_done and abandons any shot in progress. The next shot is the first of a fresh round. A restart in the same cycle as a trigger beat drops that beat and the rest of its shot.
- R10: out_start is 1 on the first published beat of a shot (position 0) and 0 on all other beats.
- R11: A written exponent above EXP_MAX is saturated to EXP_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample beat valid |
| smp_trig | input | 1 | Trigger: marks the first beat of a shot |
| smp_btn | input | 4×SAMPLE_W | Signed samples, index 0..3 = channels A..D |
| cfg_shift_exp | input | $clog2(EXP_MAX+1) | Exponent N, so a round is 2^N shots |
| cfg_shift_wr | input | 1 | Write strobe for N; also clears the round |
| cfg_hold_done | input | 1 | 1: stop after a completed round |
| cfg_show_all | input | 1 | 1: publish after every shot |
| avg_restart | input | 1 | Clear sums and start a fresh round |
| out_valid | output | 1 | Averaged beat valid |
| out_start | output | 1 | First beat of a published shot |
| out_btn | output | 4×SAMPLE_W | Averaged samples, channels A..D |
| shot_count | output | EXP_MAX+1 | Shots completed in the current round |
| round_done | output | 1 | Round of 2^N shots completed |

## Verification
A restart or exponent write can land on the same cycle as a trigger beat. Here the clear and the start of a shot compete for the sequencer. The bench raises avg_restart on the trigger beat of a shot that would otherwise be accepted, and sends the remaining beats of that burst anyway. It passes if nothing is published, shot_count and round_done read 0, and the following shot comes out alone as a fresh round. A second race has a trigger arrive inside a running shot. This is judged by checking that the shot still ends after exactly WAVE_LEN valid beats, with the counter advanced by one.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

   localparam int NUM_BTN = 4;

   // Per-beat attributes carried from the sequencer into the add stage.
   typedef struct packed {
      logic fresh;    // first shot of a round: ignore stored sum
      logic publish;  // send this beat to the output
      logic start;    // sample position zero
   } wfa_beat_t;

endpackage

// File: rtl/wfa_acc_ram.sv
module wfa_acc_ram #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 256,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/wfa_lane.sv
module wfa_lane #(
   parameter int SAMPLE_W = 16,
   parameter int ACC_W    = 32,
   parameter int EB       = 5
) (
   input  logic                fresh,
   input  logic [ACC_W-1:0]    prev,
   input  logic [SAMPLE_W-1:0] smp,
   input  logic [EB-1:0]       shift,
   output logic [ACC_W-1:0]    sum,
   output logic [SAMPLE_W-1:0] avg
);

   logic [ACC_W-1:0] smp_ext;
   logic [ACC_W-1:0] base;
   logic signed [ACC_W-1:0] scaled;

   generate
      if (ACC_W > SAMPLE_W) begin : g_ext
         assign smp_ext = {{(ACC_W-SAMPLE_W){smp[SAMPLE_W-1]}}, smp};
      end else begin : g_noext
         assign smp_ext = smp;
      end
   endgenerate

   always_comb begin
      base   = fresh ? '0 : prev;
      sum    = base + smp_ext;
      scaled = $signed(sum) >>> shift;
      avg    = scaled[SAMPLE_W-1:0];
   end

endmodule

// File: rtl/wfa_shot_ctrl.sv
module wfa_shot_ctrl
   import wfa_pkg::*;
#(
   parameter int WAVE_LEN = 256,
   parameter int EXP_MAX  = 16,
   localparam int AW = (WAVE_LEN > 1) ? $clog2(WAVE_LEN) : 1,
   localparam int EB = $clog2(EXP_MAX + 1),
   localparam int CW = EXP_MAX + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic          smp_trig,
   input  logic          hold_done,
   input  logic          show_all,
   input  logic          restart,
   input  logic          exp_wr,
   input  logic [EB-1:0] exp_in,
   output logic          beat_acc,
   output logic [AW-1:0] beat_idx,
   output wfa_beat_t     beat_info,
   output logic [EB-1:0] beat_shift,
   output logic [CW-1:0] shot_count,
   output logic          round_done
);

   logic          in_shot_q, fresh_q, last_q, done_q;
   logic [AW-1:0] idx_q;
   logic [CW-1:0] cnt_q;
   logic [EB-1:0] exp_q;

   logic          clr, take_trig, take_cont, take, end_beat;
   logic          fresh_now, last_now;
   logic [CW-1:0] full, base;
   logic [AW-1:0] idx_now;
   logic [EB-1:0] exp_sat;

   always_comb begin
      clr       = restart | exp_wr;
      full      = CW'(1) << exp_q;
      fresh_now = in_shot_q ? fresh_q : (done_q || cnt_q == '0);
      base      = fresh_now ? '0 : cnt_q;
      last_now  = in_shot_q ? last_q : ((base + CW'(1)) == full);
      idx_now   = in_shot_q ? idx_q : '0;
      take_trig = smp_valid && smp_trig && !in_shot_q && !clr && !(done_q && hold_done);
      take_cont = smp_valid && in_shot_q && !clr;
      take      = take_trig || take_cont;
      end_beat  = take && (idx_now == AW'(WAVE_LEN - 1));
      exp_sat   = (int'(exp_in) > EXP_MAX) ? EB'(EXP_MAX) : exp_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_shot_q <= 1'b0;
         fresh_q   <= 1'b0;
         last_q    <= 1'b0;
         done_q    <= 1'b0;
         idx_q     <= '0;
         cnt_q     <= '0;
         exp_q     <= EB'(1);
      end else begin
         if (exp_wr) exp_q <= exp_sat;
         if (clr) begin
            in_shot_q <= 1'b0;
            idx_q     <= '0;
            cnt_q     <= '0;
            done_q    <= 1'b0;
         end else if (take) begin
            if (take_trig) begin
               fresh_q <= fresh_now;
               last_q  <= last_now;
               if (fresh_now) begin
                  cnt_q  <= '0;
                  done_q <= 1'b0;
               end
            end
            if (end_beat) begin
               in_shot_q <= 1'b0;
               idx_q     <= '0;
               cnt_q     <= base + CW'(1);
               done_q    <= last_now;
            end else begin
               in_shot_q <= 1'b1;
               idx_q     <= idx_now + AW'(1);
            end
         end
      end
   end

   assign beat_acc          = take;
   assign beat_idx          = idx_now;
   assign beat_info.fresh   = fresh_now;
   assign beat_info.publish = show_all || last_now;
   assign beat_info.start   = (idx_now == '0);
   assign beat_shift        = exp_q;
   assign shot_count        = cnt_q;
   assign round_done        = done_q;

endmodule

// File: rtl/wfa_averager.sv
module wfa_averager
   import wfa_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int WAVE_LEN = 256,
   parameter int EXP_MAX  = 16,
   localparam int AW    = (WAVE_LEN > 1) ? $clog2(WAVE_LEN) : 1,
   localparam int EB    = $clog2(EXP_MAX + 1),
   localparam int CW    = EXP_MAX + 1,
   localparam int ACC_W = SAMPLE_W + EXP_MAX
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             smp_valid,
   input  logic                             smp_trig,
   input  logic [NUM_BTN-1:0][SAMPLE_W-1:0] smp_btn,
   input  logic [EB-1:0]                    cfg_shift_exp,
   input  logic                             cfg_shift_wr,
   input  logic                             cfg_hold_done,
   input  logic                             cfg_show_all,
   input  logic                             avg_restart,
   output logic                             out_valid,
   output logic                             out_start,
   output logic [NUM_BTN-1:0][SAMPLE_W-1:0] out_btn,
   output logic [CW-1:0]                    shot_count,
   output logic                             round_done
);

   if (WAVE_LEN < 2) begin : g_chk_len
      $error("wfa_averager: WAVE_LEN must be at least 2");
   end
   if (EXP_MAX < 1 || EXP_MAX > 30) begin : g_chk_exp
      $error("wfa_averager: EXP_MAX must lie in 1..30");
   end
   if (SAMPLE_W < 2) begin : g_chk_w
      $error("wfa_averager: SAMPLE_W must be at least 2");
   end

   // Stage 0: shot sequencer, memory read issue
   logic          beat_acc;
   logic [AW-1:0] beat_idx;
   wfa_beat_t     beat_info;
   logic [EB-1:0] exp_cur;

   wfa_shot_ctrl #(
      .WAVE_LEN (WAVE_LEN),
      .EXP_MAX  (EXP_MAX)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_valid  (smp_valid),
      .smp_trig   (smp_trig),
      .hold_done  (cfg_hold_done),
      .show_all   (cfg_show_all),
      .restart    (avg_restart),
      .exp_wr     (cfg_shift_wr),
      .exp_in     (cfg_shift_exp),
      .beat_acc   (beat_acc),
      .beat_idx   (beat_idx),
      .beat_info  (beat_info),
      .beat_shift (exp_cur),
      .shot_count (shot_count),
      .round_done (round_done)
   );

   // Stage 1: add, write back, scale
   logic                             v1;
   wfa_beat_t                        info1;
   logic [AW-1:0]                    idx1;
   logic [EB-1:0]                    shift1;
   logic [NUM_BTN-1:0][SAMPLE_W-1:0] smp1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1     <= 1'b0;
         info1  <= '0;
         idx1   <= '0;
         shift1 <= '0;
         smp1   <= '0;
      end else begin
         v1 <= beat_acc;
         if (beat_acc) begin
            info1  <= beat_info;
            idx1   <= beat_idx;
            shift1 <= exp_cur;
            smp1   <= smp_btn;
         end
      end
   end

   logic [NUM_BTN-1:0][SAMPLE_W-1:0] avg1;

   for (genvar c = 0; c < NUM_BTN; c++) begin : g_btn
      logic [ACC_W-1:0] rd;
      logic [ACC_W-1:0] sum;

      wfa_acc_ram #(
         .WIDTH (ACC_W),
         .DEPTH (WAVE_LEN)
      ) u_ram (
         .clk   (clk),
         .we    (v1),
         .waddr (idx1),
         .wdata (sum),
         .raddr (beat_idx),
         .rdata (rd)
      );

      wfa_lane #(
         .SAMPLE_W (SAMPLE_W),
         .ACC_W    (ACC_W),
         .EB       (EB)
      ) u_lane (
         .fresh (info1.fresh),
         .prev  (rd),
         .smp   (smp1[c]),
         .shift (shift1),
         .sum   (sum),
         .avg   (avg1[c])
      );
   end

   // Output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_start <= 1'b0;
         out_btn   <= '0;
      end else begin
         out_valid <= v1 && info1.publish;
         out_start <= v1 && info1.publish && info1.start;
         if (v1 && info1.publish) out_btn <= avg1;
      end
   end

endmodule

// File: rtl/wfa_averager_chk.sv
module wfa_averager_chk #(
   parameter int EXP_MAX = 16,
   localparam int EB = $clog2(EXP_MAX + 1),
   localparam int CW = EXP_MAX + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_valid,
   input logic          avg_restart,
   input logic          cfg_shift_wr,
   input logic          cfg_hold_done,
   input logic          out_valid,
   input logic          out_start,
   input logic [CW-1:0] shot_count,
   input logic          round_done,
   input logic [EB-1:0] exp_q
);

   logic [CW-1:0] full;
   assign full = CW'(1) << exp_q;

   // R3: published beats trail an input beat by two cycles
   a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(smp_valid, 2));

   // R6: counter never exceeds the round size
   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      shot_count <= full);

   // R6: counter only steps by one or returns to zero
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (shot_count != $past(shot_count)) |->
         (shot_count == $past(shot_count) + CW'(1) || shot_count == '0));

   // R7: completion flag implies a full round
   a_r7_done_full: assert property (@(posedge clk) disable iff (!rst_n)
      round_done |-> shot_count == full);

   // R8: holding after completion freezes the round
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (round_done && cfg_hold_done && !avg_restart && !cfg_shift_wr) |=>
         ($stable(shot_count) && round_done));

   // R9: clear empties the round
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (avg_restart || cfg_shift_wr) |=> (shot_count == '0 && !round_done));

   // R10: start marker only on a valid beat
   a_r10_start: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> out_valid);

endmodule

bind wfa_averager wfa_averager_chk #(.EXP_MAX(EXP_MAX)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .smp_valid     (smp_valid),
   .avg_restart   (avg_restart),
   .cfg_shift_wr  (cfg_shift_wr),
   .cfg_hold_done (cfg_hold_done),
   .out_valid     (out_valid),
   .out_start     (out_start),
   .shot_count    (shot_count),
   .round_done    (round_done),
   .exp_q         (exp_cur)
);

// File: tb/tb_wfa_averager.sv
module tb_wfa_averager;

   localparam int SW = 16;
   localparam int WL = 8;
   localparam int EM = 16;
   localparam int EB = $clog2(EM + 1);
   localparam int CW = EM + 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 smp_valid = 1'b0, smp_trig = 1'b0;
   logic [3:0][SW-1:0]   smp_btn = '0;
   logic [EB-1:0]        cfg_shift_exp = '0;
   logic                 cfg_shift_wr = 1'b0, cfg_hold_done = 1'b0;
   logic                 cfg_show_all = 1'b0, avg_restart = 1'b0;
   logic                 out_valid, out_start;
   logic [3:0][SW-1:0]   out_btn;
   logic [CW-1:0]        shot_count;
   logic                 round_done;

   always #2.5 clk = ~clk;

   wfa_averager #(.SAMPLE_W(SW), .WAVE_LEN(WL), .EXP_MAX(EM)) dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_trig(smp_trig),
      .smp_btn(smp_btn), .cfg_shift_exp(cfg_shift_exp), .cfg_shift_wr(cfg_shift_wr),
      .cfg_hold_done(cfg_hold_done), .cfg_show_all(cfg_show_all),
      .avg_restart(avg_restart), .out_valid(out_valid), .out_start(out_start),
      .out_btn(out_btn), .shot_count(shot_count), .round_done(round_done));

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   // capture of published beats
   logic [3:0][SW-1:0] cap [16];
   logic               cap_st [16];
   int                 cap_n = 0;

   always @(negedge clk) begin
      if (out_valid && cap_n < 16) begin
         cap[cap_n]    = out_btn;
         cap_st[cap_n] = out_start;
         cap_n++;
      end
   end

   // reference sums
   int msum [4][WL];
   int cur_n = 1;

   typedef struct packed {
      logic       wr;
      logic [4:0] n;
      logic       all;
      int         seed;
      logic       fresh;
      logic       pub;
      int         cnt;
      logic       done;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 5'd2, 1'b0,   100, 1'b1, 1'b0, 1, 1'b0},
      '{1'b0, 5'd2, 1'b0,   -40, 1'b0, 1'b0, 2, 1'b0},
      '{1'b0, 5'd2, 1'b0,     7, 1'b0, 1'b0, 3, 1'b0},
      '{1'b0, 5'd2, 1'b0,  -333, 1'b0, 1'b1, 4, 1'b1},
      '{1'b0, 5'd2, 1'b0,    55, 1'b1, 1'b0, 1, 1'b0},
      '{1'b1, 5'd1, 1'b1,   -90, 1'b1, 1'b1, 1, 1'b0},
      '{1'b0, 5'd1, 1'b1,    33, 1'b0, 1'b1, 2, 1'b1},
      '{1'b1, 5'd0, 1'b0, -1234, 1'b1, 1'b1, 1, 1'b1},
      '{1'b0, 5'd0, 1'b0,   777, 1'b1, 1'b1, 1, 1'b1},
      '{1'b1, 5'd3, 1'b1,     3, 1'b1, 1'b1, 1, 1'b0}
   };

   function automatic int gen(int seed, int ch, int i);
      return seed + 50 * ch - 20 * i;
   endfunction

   task automatic chk(bit ok, string req, int act, int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic model_add(int seed, bit fresh);
      for (int c = 0; c < 4; c++)
         for (int i = 0; i < WL; i++)
            msum[c][i] = (fresh ? 0 : msum[c][i]) + gen(seed, c, i);
   endtask

   task automatic cfg_write(int n);
      @(posedge clk); #1;
      cfg_shift_exp = EB'(n);
      cfg_shift_wr  = 1'b1;
      @(posedge clk); #1;
      cfg_shift_wr  = 1'b0;
   endtask

   task automatic run_shot(int seed, bit mid_trig, bit gap, bit clr_first);
      cap_n = 0;
      for (int i = 0; i < WL; i++) begin
         @(posedge clk); #1;
         smp_valid   = 1'b1;
         smp_trig    = (i == 0) || (mid_trig && i == 3);
         avg_restart = clr_first && (i == 0);
         for (int c = 0; c < 4; c++) smp_btn[c] = SW'(gen(seed, c, i));
         if (gap && i == 2) begin
            @(posedge clk); #1;
            smp_valid   = 1'b0;
            smp_trig    = 1'b1;
            avg_restart = 1'b0;
            for (int c = 0; c < 4; c++) smp_btn[c] = 16'h7777;
         end
      end
      @(posedge clk); #1;
      smp_valid   = 1'b0;
      smp_trig    = 1'b0;
      avg_restart = 1'b0;
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic check_shot(string req, bit pub, int cnt, bit done);
      int exp_beats = pub ? WL : 0;
      int bad = 0, act_v = 0, exp_v = 0;
      int st_bad = 0;
      chk(cap_n == exp_beats, {req, " published beat count"}, cap_n, exp_beats);
      if (pub && cap_n == WL) begin
         for (int i = 0; i < WL; i++) begin
            if (cap_st[i] !== (i == 0)) st_bad++;
            for (int c = 0; c < 4; c++) begin
               int e = msum[c][i] >>> cur_n;
               int a = int'($signed(cap[i][c]));
               if (a != e) begin
                  if (bad == 0) begin act_v = a; exp_v = e; end
                  bad++;
               end
            end
         end
         chk(bad == 0, {req, " R3 averaged sample"}, act_v, exp_v);
         chk(st_bad == 0, "R10 start marker", st_bad, 0);
      end
      chk(shot_count == CW'(cnt), {req, " R6 shot_count"}, int'(shot_count), cnt);
      chk(round_done == done, {req, " R7 round_done"}, int'(round_done), int'(done));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1: reset state
      chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
      chk(shot_count == '0, "R1 shot_count after reset", int'(shot_count), 0);
      chk(round_done == 1'b0, "R1 round_done after reset", int'(round_done), 0);

      // R1: default exponent 1 gives two-shot rounds
      cur_n = 1;
      cfg_show_all = 1'b0;
      run_shot(210, 0, 0, 0); model_add(210, 1);
      check_shot("R1 R5 default first", 0, 1, 0);
      run_shot(-75, 0, 0, 0); model_add(-75, 0);
      check_shot("R1 R5 default second", 1, 2, 1);

      // vector table
      for (int k = 0; k < NV; k++) begin
         if (VEC[k].wr) begin
            cur_n = int'(VEC[k].n);
            cfg_write(cur_n);
         end
         cfg_show_all = VEC[k].all;
         run_shot(VEC[k].seed, 0, 0, 0);
         model_add(VEC[k].seed, VEC[k].fresh);
         check_shot($sformatf("R4 R5 R7 row%0d", k), VEC[k].pub, VEC[k].cnt, VEC[k].done);
      end

      // R8: hold after completion, then R9 restart
      cur_n = 0; cfg_write(0);
      cfg_hold_done = 1'b1; cfg_show_all = 1'b0;
      run_shot(10, 0, 0, 0); model_add(10, 1);
      check_shot("R8 first round", 1, 1, 1);
      run_shot(20, 0, 0, 0);
      check_shot("R8 held trigger", 0, 1, 1);
      @(posedge clk); #1 avg_restart = 1'b1;
      @(posedge clk); #1 avg_restart = 1'b0;
      chk(shot_count == '0 && !round_done, "R9 restart clears", int'(shot_count), 0);
      run_shot(30, 0, 0, 0); model_add(30, 1);
      check_shot("R9 after restart", 1, 1, 1);
      cfg_hold_done = 1'b0;

      // R2: trigger inside a shot and an idle beat
      cur_n = 1; cfg_write(1);
      cfg_show_all = 1'b1;
      run_shot(-500, 1, 1, 0); model_add(-500, 1);
      check_shot("R2 mid trigger and gap", 1, 1, 0);

      // R9: restart on the trigger beat drops the shot
      run_shot(400, 0, 0, 1);
      check_shot("R9 restart with trigger", 0, 0, 0);
      run_shot(-61, 0, 0, 0); model_add(-61, 1);
      check_shot("R9 fresh after drop", 1, 1, 0);

      // R11: oversized exponent saturates to EXP_MAX (round not done after one shot)
      cur_n = EM; cfg_write(31);
      run_shot(1000, 0, 0, 0); model_add(1000, 1);
      check_shot("R11 saturated exponent", 1, 1, 0);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule